// File: doc/BRIEF.md
# Triggered Pipeline Peak-Finding Digitizer

This block sits behind the ADC of one calorimeter channel. Each incoming code is 10 bits wide and comes with a 2-bit gain-range code. The block first turns the pair into one linear 15-bit amplitude. It then holds each amplitude in a delay line whose length equals the level-1 trigger latency. At 20 MHz sampling and 2.4 µs latency that is 48 samples by default. When a level-1 accept arrives, the samples that leave the delay line over a fixed window are searched for their largest value.

Each finished search produces one result: the peak amplitude, the position of the peak inside the window, and a 12-bit event tag. The result goes into a small first-word-fall-through FIFO, which a bus-side reader drains at its own pace. A trigger that arrives while a search is running is counted and otherwise ignored. A result that finds the FIFO full is thrown away, and a sticky overflow flag records the loss.

Top module: `trig_peak_digitizer`

## Requirements
- R1: The 15-bit linear amplitude is the 10-bit code shifted left by a number of bits set by the range code: range 0 shifts by 0, range 1 by 2, range 2 by 4 and range 3 by 5.
- R2: An amplitude reaches the search input exactly PIPE_DEPTH sample-enable pulses after it was taken in. Cycles with `smp_valid` low neither move the delay line nor advance a search.
- R3: An accept that arrives when no search is running starts a search on the next cycle. The search covers the amplitudes presented on the next WIN_LEN enable pulses and reports the largest of them.
- R4: `rd_index` is the 0-based position of the peak within the window (0 to WIN_LEN-1). When several samples share the largest value, the earliest one is reported.
- R5: An accept that arrives while a search is running is dropped. It adds one to `drop_count`, leaves the running search and its result unchanged, and creates no FIFO entry.
- R6: Each accepted trigger takes the current value of a 12-bit event counter as its tag, and the counter then increments. The first accepted trigger after reset gets tag 0. The counter increments even if that result is later discarded.
- R7: A result appears on the read side (`rd_valid` high) in the cycle after the clock edge of the last window sample. Results come out in order. A cycle with `rd_en` high and `rd_valid` high removes the head entry.
- R8: A result produced while the FIFO already holds FIFO_DEPTH entries is discarded. `overflow` then goes high and stays high until reset.
- R9: A synchronous reset clears the delay line to zero, empties the FIFO, and clears the event counter, the drop counter, the overflow flag and any running search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample enable, one pulse per ADC sample |
| smp_code | input | 10 | Raw ADC code |
| smp_range | input | 2 | Gain-range code for the sample |
| l1_accept | input | 1 | Level-1 trigger accept |
| rd_en | input | 1 | Removes the FIFO head entry |
| rd_valid | output | 1 | FIFO holds at least one result |
| rd_peak | output | 15 | Peak amplitude of the head entry |
| rd_index | output | IDX_W (5) | Peak position inside the window |
| rd_event | output | 12 | Event tag of the head entry |
| search_busy | output | 1 | A window search is running |
| overflow | output | 1 | Sticky flag: a result was lost to a full FIFO |
| drop_count | output | 8 | Accepts dropped during a running search (wraps) |

## Verification
Several situations can only be reached by precise timing at the ports. A second accept must arrive while the window is still open. A ranged sample must land at a chosen window position. The FIFO must be filled with results until one is lost. The bench places each sample relative to the accept using the delay depth. It then pushes a retrigger into the middle of a window, inserts idle cycles into one window, and runs five searches without reading so that the fifth result meets a full FIFO. A reset issued while results are pending must leave a zeroed delay line behind. To show this, the bench triggers immediately after reset while non-zero codes flow in, and expects a peak of zero.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
    localparam int RAW_W    = 10;
    localparam int RANGE_W  = 2;
    localparam int SAMPLE_W = 15;
    localparam int EVT_W    = 12;
    localparam int DROP_W   = 8;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [EVT_W-1:0]    evt_t;
endpackage

// File: rtl/tpd_range_expander.sv
module tpd_range_expander
    import tpd_pkg::*;
(
    input  logic [RAW_W-1:0]   code_i,
    input  logic [RANGE_W-1:0] range_i,
    output sample_t            lin_o
);
    localparam int PAD_W = SAMPLE_W - RAW_W;

    sample_t ext;

    // Gain ranges map to shifts of 0, 2, 4 and 5 bits.
    always_comb begin
        ext = {{PAD_W{1'b0}}, code_i};
        unique case (range_i)
            2'd0:    lin_o = ext;
            2'd1:    lin_o = ext << 2;
            2'd2:    lin_o = ext << 4;
            default: lin_o = ext << 5;
        endcase
    end
endmodule

// File: rtl/tpd_delay_line.sv
module tpd_delay_line
    import tpd_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    shift_i,
    input  sample_t din_i,
    output sample_t tap_o
);
    sample_t line_d [DEPTH];
    sample_t line_q [DEPTH];

    always_comb begin
        line_d = line_q;
        if (shift_i) begin
            line_d[0] = din_i;
            for (int i = 1; i < DEPTH; i++) begin
                line_d[i] = line_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            line_q <= line_d;
        end
    end

    assign tap_o = line_q[DEPTH-1];

    // R2
    tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(tap_o));
endmodule

// File: rtl/tpd_peak_search.sv
module tpd_peak_search
    import tpd_pkg::*;
#(
    parameter int WIN   = 30,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              trig_i,
    input  sample_t           tap_i,
    output logic              push_o,
    output sample_t           peak_o,
    output logic [IDX_W-1:0]  idx_o,
    output evt_t              evt_o,
    output logic              busy_o,
    output logic [DROP_W-1:0] drops_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN - 1);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  cnt;
        sample_t           best;
        logic [IDX_W-1:0]  best_idx;
        evt_t              tag;
        evt_t              evt_next;
        logic [DROP_W-1:0] drops;
    } st_t;

    st_t st_d, st_q;
    logic take;
    sample_t cand_best;
    logic [IDX_W-1:0] cand_idx;

    always_comb begin
        st_d      = st_q;
        push_o    = 1'b0;
        // Strict compare keeps the earliest of equal maxima.
        take      = step_i && ((st_q.cnt == '0) || (tap_i > st_q.best));
        cand_best = take ? tap_i    : st_q.best;
        cand_idx  = take ? st_q.cnt : st_q.best_idx;
        if (st_q.busy) begin
            if (trig_i) begin
                st_d.drops = st_q.drops + 1'b1;
            end
            if (step_i) begin
                st_d.best     = cand_best;
                st_d.best_idx = cand_idx;
                if (st_q.cnt == LAST) begin
                    push_o    = 1'b1;
                    st_d.busy = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else if (trig_i) begin
            st_d.busy     = 1'b1;
            st_d.cnt      = '0;
            st_d.tag      = st_q.evt_next;
            st_d.evt_next = st_q.evt_next + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign peak_o  = cand_best;
    assign idx_o   = cand_idx;
    assign evt_o   = st_q.tag;
    assign busy_o  = st_q.busy;
    assign drops_o = st_q.drops;

    // R5
    retrig_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && trig_i) |=> (drops_o != $past(drops_o)));

    // R5
    retrig_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && trig_i) |=> $stable(evt_o));

    // R3
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        push_o |=> !busy_o);
endmodule

// File: rtl/tpd_result_fifo.sv
module tpd_result_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } fst_t;

    fst_t fs_d, fs_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop, full;

    always_comb begin
        fs_d    = fs_q;
        full    = (fs_q.count == FULL_CNT);
        do_push = push_i && !full;
        do_pop  = pop_i && (fs_q.count != '0);
        if (push_i && full) begin
            fs_d.ovf = 1'b1;
        end
        if (do_push) begin
            fs_d.wptr = (fs_q.wptr == LAST_PTR) ? '0 : fs_q.wptr + 1'b1;
        end
        if (do_pop) begin
            fs_d.rptr = (fs_q.rptr == LAST_PTR) ? '0 : fs_q.rptr + 1'b1;
        end
        if (do_push && !do_pop) begin
            fs_d.count = fs_q.count + 1'b1;
        end else if (do_pop && !do_push) begin
            fs_d.count = fs_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[fs_q.wptr] <= data_i;
        end
    end

    assign valid_o = (fs_q.count != '0);
    assign data_o  = mem[fs_q.rptr];
    assign ovf_o   = fs_q.ovf;

    // R8
    full_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && fs_q.count == FULL_CNT) |=> ovf_o);

    // R8
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);
endmodule

// File: rtl/trig_peak_digitizer.sv
module trig_peak_digitizer
    import tpd_pkg::*;
#(
    parameter int PIPE_DEPTH = 48,
    parameter int WIN_LEN    = 30,
    parameter int FIFO_DEPTH = 16,
    parameter int IDX_W      = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [9:0]        smp_code,
    input  logic [1:0]        smp_range,
    input  logic              l1_accept,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [14:0]       rd_peak,
    output logic [IDX_W-1:0]  rd_index,
    output logic [11:0]       rd_event,
    output logic              search_busy,
    output logic              overflow,
    output logic [7:0]        drop_count
);
    localparam int ENTRY_W = IDX_W + EVT_W + SAMPLE_W;

    sample_t lin, tap, peak;
    logic push;
    logic [IDX_W-1:0] idx;
    evt_t evt;
    logic [ENTRY_W-1:0] head;

    tpd_range_expander u_expand (
        .code_i  (smp_code),
        .range_i (smp_range),
        .lin_o   (lin)
    );

    tpd_delay_line #(.DEPTH(PIPE_DEPTH)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .shift_i (smp_valid),
        .din_i   (lin),
        .tap_o   (tap)
    );

    tpd_peak_search #(.WIN(WIN_LEN), .IDX_W(IDX_W)) u_search (
        .clk     (clk),
        .rst     (rst),
        .step_i  (smp_valid),
        .trig_i  (l1_accept),
        .tap_i   (tap),
        .push_o  (push),
        .peak_o  (peak),
        .idx_o   (idx),
        .evt_o   (evt),
        .busy_o  (search_busy),
        .drops_o (drop_count)
    );

    tpd_result_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .data_i  ({idx, evt, peak}),
        .pop_i   (rd_en),
        .valid_o (rd_valid),
        .data_o  (head),
        .ovf_o   (overflow)
    );

    assign {rd_index, rd_event, rd_peak} = head;

    // R7
    pop_only_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> $past(rd_en));
endmodule

// File: tb/trig_peak_digitizer_bench.sv
module trig_peak_digitizer_bench;
    localparam int DEPTH = 8;
    localparam int WIN   = 6;
    localparam int FD    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [9:0] smp_code = '0;
    logic [1:0] smp_range = '0;
    logic l1_accept = 1'b0;
    logic rd_en = 1'b0;
    logic rd_valid, search_busy, overflow;
    logic [14:0] rd_peak;
    logic [2:0] rd_index;
    logic [11:0] rd_event;
    logic [7:0] drop_count;

    int checks = 0;
    int errors = 0;
    int evt_exp = 0;

    always #10 clk = ~clk;

    trig_peak_digitizer #(.PIPE_DEPTH(DEPTH), .WIN_LEN(WIN), .FIFO_DEPTH(FD)) u_trig_peak_digitizer (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
        .smp_range(smp_range), .l1_accept(l1_accept), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_peak(rd_peak), .rd_index(rd_index),
        .rd_event(rd_event), .search_busy(search_busy), .overflow(overflow),
        .drop_count(drop_count)
    );

    typedef struct packed {
        logic [1:0]  r;
        logic [9:0]  c;
        logic [14:0] exp;
        logic [2:0]  k;
    } vec_t;

    // R1 table: range, code, expected linear value, window position
    localparam vec_t VEC [8] = '{
        '{2'd0, 10'h3FF, 15'd1023,  3'd0},
        '{2'd1, 10'h3FF, 15'd4092,  3'd5},
        '{2'd2, 10'h3FF, 15'd16368, 3'd2},
        '{2'd3, 10'h3FF, 15'd32736, 3'd3},
        '{2'd3, 10'h001, 15'd32,    3'd1},
        '{2'd2, 10'h155, 15'd5456,  3'd4},
        '{2'd1, 10'h200, 15'd2048,  3'd0},
        '{2'd0, 10'h0AB, 15'd171,   3'd5}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [9:0] c, input logic [1:0] r, input logic v, input logic t);
        @(negedge clk);
        smp_code = c; smp_range = r; smp_valid = v; l1_accept = t;
    endtask

    task automatic pop_check(input string req, input int peak, input int idx, input int evt);
        @(negedge clk);
        smp_valid = 1'b0; l1_accept = 1'b0; smp_code = '0; smp_range = '0;
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " peak"}, int'(rd_peak), peak);
        check({req, " index"}, int'(rd_index), idx);
        check({req, " event"}, int'(rd_event), evt);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Window with accept on step DEPTH-1 so step i lands at index i.
    task automatic run_win(input logic [9:0] w [WIN], input bit gaps, input int retrig_at);
        for (int s = 0; s < DEPTH + WIN + 3; s++) begin
            if (gaps && s >= DEPTH && s[0]) step(10'h3FF, 2'd3, 1'b0, 1'b0);
            step((s < WIN) ? w[s] : 10'd0, 2'd0, 1'b1, (s == DEPTH - 1) || (s == retrig_at));
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [9:0] w [WIN];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 rd_valid after reset", int'(rd_valid), 0);
        check("R9 overflow after reset", int'(overflow), 0);
        check("R9 drop_count after reset", int'(drop_count), 0);
        check("R9 busy after reset", int'(search_busy), 0);

        // R1 R2 R3 R6 R7 table walk
        foreach (VEC[n]) begin
            for (int s = 0; s < DEPTH + WIN + 3; s++) begin
                step((s == 0) ? VEC[n].c : 10'd0, (s == 0) ? VEC[n].r : 2'd0,
                     1'b1, s == DEPTH - 1 - int'(VEC[n].k));
            end
            pop_check("R1 R2 R3 table", int'(VEC[n].exp), int'(VEC[n].k), evt_exp);
            evt_exp++;
        end

        // R4 ties: earliest of equal maxima
        w = '{10'd5, 10'd9, 10'd3, 10'd9, 10'd1, 10'd9};
        run_win(w, 1'b0, -1);
        pop_check("R4 tie", 9, 1, evt_exp);
        evt_exp++;

        // R2 R4 idle cycles inside window, peak at last index
        w = '{10'd1, 10'd2, 10'd3, 10'd4, 10'd5, 10'd6};
        run_win(w, 1'b1, -1);
        pop_check("R2 R4 gaps last index", 6, 5, evt_exp);
        evt_exp++;

        // R5 retrigger mid-window
        w = '{10'd0, 10'd0, 10'd7, 10'd0, 10'd0, 10'd0};
        run_win(w, 1'b0, DEPTH + 2);
        check("R5 drop_count", int'(drop_count), 1);
        pop_check("R5 retrigger result", 7, 2, evt_exp);
        evt_exp++;
        check("R5 no extra entry", int'(rd_valid), 0);

        // R8 overflow: five results, FIFO holds four
        for (int n = 0; n < 5; n++) begin
            w = '{10'd0, 10'd0, 10'd0, 10'(n + 1), 10'd0, 10'd0};
            run_win(w, 1'b0, -1);
        end
        @(negedge clk);
        check("R8 overflow set", int'(overflow), 1);
        for (int n = 0; n < 4; n++) begin
            pop_check("R8 R7 kept entry", n + 1, 3, evt_exp + n);
        end
        check("R8 fifth discarded", int'(rd_valid), 0);
        check("R8 overflow sticky", int'(overflow), 1);
        evt_exp += 5;

        // R6 tag continues past discarded result
        w = '{10'd4, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0};
        run_win(w, 1'b0, -1);
        pop_check("R6 tag after discard", 4, 0, evt_exp);

        // R9 reset with pending entry clears everything
        run_win(w, 1'b0, -1);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 fifo empty", int'(rd_valid), 0);
        check("R9 overflow cleared", int'(overflow), 0);
        check("R9 drops cleared", int'(drop_count), 0);
        for (int s = 0; s < WIN + 3; s++) begin
            step(10'h3FF, 2'd3, 1'b1, s == 0);
        end
        pop_check("R9 pipeline zeroed tag zero", 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule